// File: doc/BRIEF.md
# Vector Structure Transfer Sequencer

This block turns one already-decoded vector structure load or store into the ordered list of micro-operations that carries it out. The command gives the transfer direction, how many vector registers move, how many elements form one structure, the element size, the general base register, the first vector register, the register stride, the requested alignment and the post-increment selector. The block then hands out one micro-op per accepted handshake. Each micro-op is one of three kinds. A memory beat moves up to 16 bytes. A base writeback updates the address register. A shuffle interleaves or de-interleaves structure elements between the architectural vector registers and scratch registers that sit just above the architectural file.

The sequencer accepts a new command only while it is idle. It rejects an unsupported shape with a one-cycle flag and emits no micro-ops for it. The count and the order of the micro-ops follow from the register count, the structure size and the writeback selector, so one decode slot can feed a fixed-width micro-op queue.

Top module: `vxs_seq`

## Requirements
- R1: A command is legal only when `in_nregs` is 1 to 4, `in_elems` is 1 to 4 and `in_nregs` is a multiple of `in_elems`. If an illegal command is accepted, `illegal` is 1 for exactly the following cycle and no micro-op is emitted.
- R2: A command with 1 or 2 registers produces one memory beat, and a command with 3 or 4 registers produces two. The first beat has `uop_offset` 0, `uop_align_en`=1 and `uop_align` equal to the requested code. The second beat has `uop_offset` 16, `uop_align_en`=0 and `uop_align` 0.
- R3: The data register of a memory beat is 2×`in_vd` when `in_elems` is 1. Otherwise it is the scratch base, which equals the number of architectural FP registers (64 by default). The second beat adds 4. `uop_src` is 0.
- R4: Writeback happens when `in_postinc` is not 15. When it is 13, the writeback has `uop_use_imm`=1 and `uop_imm` = 8×`in_nregs`. When it is any other value, `uop_use_imm`=0 and `uop_incr_reg` = `in_postinc`. `uop_base` always carries `in_base`.
- R5: When `in_elems` is greater than 1, the command produces `in_nregs`/`in_elems` shuffles. Otherwise it produces none.
- R6: Shuffle k (0 or 1) pairs vector register 2×`in_vd`+2k with scratch register scratch base+4k, and carries `uop_stride` = 2×`in_stride`. For loads the vector register is `uop_dst` and the scratch register is `uop_src`. For stores the two are swapped.
- R7: `uop_kind` encodes 0 as memory, 1 as writeback and 2 as shuffle. Loads emit their memory beats, then the writeback, then the shuffles. Stores emit their shuffles, then the memory beats, then the writeback. Fields that a kind does not use are 0, and every micro-op carries `uop_esize`.
- R8: Every micro-op has `uop_delayed`=1 and `uop_last`=0, except the final one, which has `uop_delayed`=0 and `uop_last`=1.
- R9: `in_ready` is 1 only while no micro-op is pending. While `uop_ready` is 0, the current micro-op holds steady. The block is idle in the cycle after the last micro-op is accepted, and it is idle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Sequencer idle, command taken |
| in_store | input | 1 | 1 = store, 0 = load |
| in_nregs | input | 3 | Vector registers moved |
| in_elems | input | 3 | Elements per structure |
| in_esize | input | 2 | Element size code |
| in_base | input | 4 | Base general register |
| in_vd | input | 5 | First vector register |
| in_stride | input | 2 | Register stride |
| in_align | input | 2 | Requested alignment code |
| in_postinc | input | 4 | Post-increment selector |
| illegal | output | 1 | Rejected command pulse |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Downstream takes micro-op |
| uop_kind | output | 2 | 0 memory, 1 writeback, 2 shuffle |
| uop_last | output | 1 | Final micro-op |
| uop_delayed | output | 1 | Commit deferred |
| uop_dst | output | 7 | Data/destination register |
| uop_src | output | 7 | Shuffle source register |
| uop_offset | output | 5 | Memory byte offset |
| uop_align_en | output | 1 | Alignment check on |
| uop_align | output | 2 | Alignment code |
| uop_esize | output | 2 | Element size |
| uop_base | output | 4 | Base general register |
| uop_use_imm | output | 1 | Writeback adds immediate |
| uop_imm | output | 6 | Writeback immediate |
| uop_incr_reg | output | 4 | Writeback increment register |
| uop_stride | output | 3 | Shuffle register stride |

## Verification
The bench sweeps both directions, every 3-bit register count and every 3-bit element count against three post-increment selectors, and drives a stalling ready pattern. The corner cases it targets are these. A 4-register, 2-element transfer must produce two shuffles, and a design that dropped the second shuffle would leave half the registers unshuffled. The second memory beat must have its alignment check off, and keeping it on would fault on legal addresses. Selector 13 must add an immediate, and treating it as a register would add a stack pointer instead. Store order is reversed against load order, and a shared ordering would write memory before the data is interleaved. Shapes such as 3 registers with 2 elements, or a zero count, must be refused silently.

// File: rtl/vxs_pkg.sv
package vxs_pkg;

    localparam int ARCH_FP_REGS   = 64;
    localparam int VREG_W         = 7;
    localparam int VD_W           = 5;
    localparam int GPR_W          = 4;
    localparam int CNT_W          = 3;
    localparam int SZ_W           = 2;
    localparam int ALN_W          = 2;
    localparam int STR_W          = 2;
    localparam int OFF_W          = 5;
    localparam int IMM_W          = 6;
    localparam int IDX_W          = 3;
    localparam int TAIL_BEAT_OFS  = 16;
    localparam int MAX_REGS       = 4;

    typedef enum logic [1:0] {
        UK_MEM  = 2'd0,
        UK_WB   = 2'd1,
        UK_SHUF = 2'd2
    } uop_kind_e;

    // command fields retained while a transfer is being expanded
    typedef struct packed {
        logic              store;
        logic [CNT_W-1:0]  nregs;
        logic [SZ_W-1:0]   esize;
        logic [GPR_W-1:0]  base;
        logic [VD_W-1:0]   vd;
        logic [STR_W-1:0]  stride;
        logic [ALN_W-1:0]  align;
        logic [GPR_W-1:0]  postinc;
    } xfer_cmd_t;

    typedef struct packed {
        logic [1:0]       n_mem;
        logic             wb;
        logic             wb_imm;
        logic [1:0]       n_shuf;
        logic             interleave;
        logic [IDX_W-1:0] total;
    } xfer_plan_t;

    typedef struct packed {
        uop_kind_e         kind;
        logic              last;
        logic              delayed;
        logic [VREG_W-1:0] dst;
        logic [VREG_W-1:0] src;
        logic [OFF_W-1:0]  offset;
        logic              align_en;
        logic [ALN_W-1:0]  align;
        logic [SZ_W-1:0]   esize;
        logic [GPR_W-1:0]  base;
        logic              use_imm;
        logic [IMM_W-1:0]  imm;
        logic [GPR_W-1:0]  incr_reg;
        logic [STR_W:0]    stride;
    } uop_t;

    function automatic logic shape_ok(input logic [CNT_W-1:0] nregs,
                                      input logic [CNT_W-1:0] elems);
        logic ok;
        case (elems)
            3'd1:    ok = (nregs != '0) && (nregs <= CNT_W'(MAX_REGS));
            3'd2:    ok = (nregs == 3'd2) || (nregs == 3'd4);
            3'd3:    ok = (nregs == 3'd3);
            3'd4:    ok = (nregs == 3'd4);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic [1:0] shuffle_count(input logic [CNT_W-1:0] nregs,
                                                 input logic [CNT_W-1:0] elems);
        if (elems == 3'd2 && nregs == 3'd4) return 2'd2;
        if (elems > 3'd1)                   return 2'd1;
        return 2'd0;
    endfunction

endpackage

// File: rtl/vxs_decode.sv
module vxs_decode
    import vxs_pkg::*;
#(
    parameter int NO_WB_SEL  = 15,
    parameter int IMM_WB_SEL = 13
) (
    input  logic [CNT_W-1:0] nregs,
    input  logic [CNT_W-1:0] elems,
    input  logic [GPR_W-1:0] postinc,
    output logic             legal,
    output xfer_plan_t       plan
);
    always_comb begin
        legal           = shape_ok(nregs, elems);
        plan.n_mem      = (nregs > 3'd2) ? 2'd2 : 2'd1;
        plan.wb         = (postinc != GPR_W'(NO_WB_SEL));
        plan.wb_imm     = (postinc == GPR_W'(IMM_WB_SEL));
        plan.n_shuf     = shuffle_count(nregs, elems);
        plan.interleave = (elems > 3'd1);
        plan.total      = IDX_W'(plan.n_mem) + IDX_W'(plan.wb) + IDX_W'(plan.n_shuf);
    end
endmodule

// File: rtl/vxs_slot_map.sv
module vxs_slot_map
    import vxs_pkg::*;
(
    input  logic             store,
    input  logic [1:0]       n_mem,
    input  logic             wb,
    input  logic [1:0]       n_shuf,
    input  logic [IDX_W-1:0] idx,
    output uop_kind_e        kind,
    output logic             sub
);
    logic [IDX_W-1:0] mem_n, wb_n, shuf_n, rel;

    always_comb begin
        mem_n  = IDX_W'(n_mem);
        wb_n   = IDX_W'(wb);
        shuf_n = IDX_W'(n_shuf);
        rel    = '0;
        kind   = UK_MEM;
        if (store) begin
            // shuffles, memory beats, writeback
            if (idx < shuf_n) begin
                kind = UK_SHUF;
                rel  = idx;
            end else if (idx < shuf_n + mem_n) begin
                kind = UK_MEM;
                rel  = idx - shuf_n;
            end else begin
                kind = UK_WB;
            end
        end else begin
            // memory beats, writeback, shuffles
            if (idx < mem_n) begin
                kind = UK_MEM;
                rel  = idx;
            end else if (wb && idx == mem_n) begin
                kind = UK_WB;
            end else begin
                kind = UK_SHUF;
                rel  = idx - mem_n - wb_n;
            end
        end
        sub = rel[0];
    end
endmodule

// File: rtl/vxs_uop_build.sv
module vxs_uop_build
    import vxs_pkg::*;
#(
    parameter int NUM_FP = ARCH_FP_REGS
) (
    input  logic              store,
    input  logic [CNT_W-1:0]  nregs,
    input  logic [SZ_W-1:0]   esize,
    input  logic [GPR_W-1:0]  base,
    input  logic [VD_W-1:0]   vd,
    input  logic [STR_W-1:0]  stride,
    input  logic [ALN_W-1:0]  align,
    input  logic [GPR_W-1:0]  postinc,
    input  logic              interleave,
    input  logic              wb_imm,
    input  uop_kind_e         kind,
    input  logic              sub,
    input  logic              last,
    output uop_t              uop
);
    localparam logic [VREG_W-1:0] SCRATCH = VREG_W'(NUM_FP);

    logic [VREG_W-1:0] vreg_pair, scratch_pair, beat_reg;

    always_comb begin
        vreg_pair    = VREG_W'({vd, 1'b0}) + VREG_W'({sub, 1'b0});
        scratch_pair = SCRATCH + VREG_W'({sub, 2'b00});
        beat_reg     = (interleave ? SCRATCH : VREG_W'({vd, 1'b0})) + VREG_W'({sub, 2'b00});

        uop          = '0;
        uop.kind     = kind;
        uop.last     = last;
        uop.delayed  = !last;
        uop.esize    = esize;
        uop.base     = base;
        case (kind)
            UK_MEM: begin
                uop.dst      = beat_reg;
                uop.offset   = sub ? OFF_W'(TAIL_BEAT_OFS) : '0;
                uop.align_en = !sub;
                uop.align    = sub ? '0 : align;
            end
            UK_WB: begin
                uop.use_imm  = wb_imm;
                uop.imm      = wb_imm ? IMM_W'({nregs, 3'b000}) : '0;
                uop.incr_reg = wb_imm ? '0 : postinc;
            end
            default: begin
                uop.dst    = store ? scratch_pair : vreg_pair;
                uop.src    = store ? vreg_pair : scratch_pair;
                uop.stride = {stride, 1'b0};
            end
        endcase
    end
endmodule

// File: rtl/vxs_seq.sv
module vxs_seq
    import vxs_pkg::*;
#(
    parameter int NUM_FP     = ARCH_FP_REGS,
    parameter int NO_WB_SEL  = 15,
    parameter int IMM_WB_SEL = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_store,
    input  logic [2:0]  in_nregs,
    input  logic [2:0]  in_elems,
    input  logic [1:0]  in_esize,
    input  logic [3:0]  in_base,
    input  logic [4:0]  in_vd,
    input  logic [1:0]  in_stride,
    input  logic [1:0]  in_align,
    input  logic [3:0]  in_postinc,
    output logic        illegal,
    output logic        uop_valid,
    input  logic        uop_ready,
    output logic [1:0]  uop_kind,
    output logic        uop_last,
    output logic        uop_delayed,
    output logic [6:0]  uop_dst,
    output logic [6:0]  uop_src,
    output logic [4:0]  uop_offset,
    output logic        uop_align_en,
    output logic [1:0]  uop_align,
    output logic [1:0]  uop_esize,
    output logic [3:0]  uop_base,
    output logic        uop_use_imm,
    output logic [5:0]  uop_imm,
    output logic [3:0]  uop_incr_reg,
    output logic [2:0]  uop_stride
);
    xfer_cmd_t        cmd_d, cmd_q;
    xfer_plan_t       plan_d, plan_q;
    logic             legal_d;
    logic             busy_q, illegal_q;
    logic [IDX_W-1:0] idx_q;
    logic             accept, at_last, sub;
    uop_kind_e        kind;
    uop_t             uop;

    always_comb begin
        cmd_d.store   = in_store;
        cmd_d.nregs   = in_nregs;
        cmd_d.esize   = in_esize;
        cmd_d.base    = in_base;
        cmd_d.vd      = in_vd;
        cmd_d.stride  = in_stride;
        cmd_d.align   = in_align;
        cmd_d.postinc = in_postinc;
    end

    vxs_decode #(
        .NO_WB_SEL  (NO_WB_SEL),
        .IMM_WB_SEL (IMM_WB_SEL)
    ) i_decode (
        .nregs   (in_nregs),
        .elems   (in_elems),
        .postinc (in_postinc),
        .legal   (legal_d),
        .plan    (plan_d)
    );

    assign in_ready = !busy_q;
    assign accept   = in_valid && in_ready;
    assign at_last  = (idx_q == plan_q.total - IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            illegal_q <= 1'b0;
            idx_q     <= '0;
            cmd_q     <= '0;
            plan_q    <= '0;
        end else begin
            illegal_q <= accept && !legal_d;
            if (accept && legal_d) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                cmd_q  <= cmd_d;
                plan_q <= plan_d;
            end else if (busy_q && uop_ready) begin
                if (at_last) begin
                    busy_q <= 1'b0;
                    idx_q  <= '0;
                end else begin
                    idx_q  <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    vxs_slot_map i_slot_map (
        .store  (cmd_q.store),
        .n_mem  (plan_q.n_mem),
        .wb     (plan_q.wb),
        .n_shuf (plan_q.n_shuf),
        .idx    (idx_q),
        .kind   (kind),
        .sub    (sub)
    );

    vxs_uop_build #(
        .NUM_FP (NUM_FP)
    ) i_uop_build (
        .store      (cmd_q.store),
        .nregs      (cmd_q.nregs),
        .esize      (cmd_q.esize),
        .base       (cmd_q.base),
        .vd         (cmd_q.vd),
        .stride     (cmd_q.stride),
        .align      (cmd_q.align),
        .postinc    (cmd_q.postinc),
        .interleave (plan_q.interleave),
        .wb_imm     (plan_q.wb_imm),
        .kind       (kind),
        .sub        (sub),
        .last       (at_last),
        .uop        (uop)
    );

    assign illegal      = illegal_q;
    assign uop_valid    = busy_q;
    assign uop_kind     = uop.kind;
    assign uop_last     = uop.last;
    assign uop_delayed  = uop.delayed;
    assign uop_dst      = uop.dst;
    assign uop_src      = uop.src;
    assign uop_offset   = uop.offset;
    assign uop_align_en = uop.align_en;
    assign uop_align    = uop.align;
    assign uop_esize    = uop.esize;
    assign uop_base     = uop.base;
    assign uop_use_imm  = uop.use_imm;
    assign uop_imm      = uop.imm;
    assign uop_incr_reg = uop.incr_reg;
    assign uop_stride   = uop.stride;
endmodule

// File: rtl/vxs_seq_chk.sv
module vxs_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       illegal,
    input logic       uop_valid,
    input logic       uop_ready,
    input logic [1:0] uop_kind,
    input logic       uop_last,
    input logic [4:0] uop_offset,
    input logic       uop_align_en,
    input logic       uop_use_imm,
    input logic [5:0] uop_imm
);
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !uop_valid);  // R1

    AST_TAIL_BEAT_NOALIGN: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_kind == 2'd0 && uop_offset != 5'd0) |-> !uop_align_en);  // R2

    AST_IMM_SCALED: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_kind == 2'd1 && uop_use_imm) |->
            (uop_imm[2:0] == 3'd0 && uop_imm != 6'd0 && uop_imm <= 6'd32));  // R4

    AST_KIND_ENCODED: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> (uop_kind != 2'd3));  // R7

    AST_DRAIN_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_ready && uop_last) |=> !uop_valid);  // R8

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        uop_valid |-> !in_ready);  // R9

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && !uop_ready) |=>
            (uop_valid && $stable(uop_kind) && $stable(uop_last) && $stable(uop_offset)));  // R9
endmodule

bind vxs_seq vxs_seq_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .illegal      (illegal),
    .uop_valid    (uop_valid),
    .uop_ready    (uop_ready),
    .uop_kind     (uop_kind),
    .uop_last     (uop_last),
    .uop_offset   (uop_offset),
    .uop_align_en (uop_align_en),
    .uop_use_imm  (uop_use_imm),
    .uop_imm      (uop_imm)
);

// File: tb/test_vxs_seq.sv
`timescale 1ns/1ps
module test_vxs_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_store = 1'b0;
    logic [2:0] in_nregs = '0;
    logic [2:0] in_elems = '0;
    logic [1:0] in_esize = '0;
    logic [3:0] in_base = '0;
    logic [4:0] in_vd = '0;
    logic [1:0] in_stride = '0;
    logic [1:0] in_align = '0;
    logic [3:0] in_postinc = '0;
    logic       illegal;
    logic       uop_valid;
    logic       uop_ready = 1'b0;
    logic [1:0] uop_kind;
    logic       uop_last, uop_delayed;
    logic [6:0] uop_dst, uop_src;
    logic [4:0] uop_offset;
    logic       uop_align_en;
    logic [1:0] uop_align, uop_esize;
    logic [3:0] uop_base;
    logic       uop_use_imm;
    logic [5:0] uop_imm;
    logic [3:0] uop_incr_reg;
    logic [2:0] uop_stride;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int SCR = 64;

    always #4 clk = ~clk;

    vxs_seq i_vxs_seq (.*);

    logic [45:0] e_vec [8];
    int          e_n;

    function automatic logic [45:0] mk(input int kind, input int dst, input int src,
                                       input int off, input int alen, input int aln,
                                       input int esz, input int base, input int useimm,
                                       input int imm, input int incr, input int strd);
        return {2'(kind), 1'b0, 1'b1, 7'(dst), 7'(src), 5'(off), 1'(alen), 2'(aln),
                2'(esz), 4'(base), 1'(useimm), 6'(imm), 4'(incr), 3'(strd)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic build_expect(input bit st, input int nr, input int el, input int esz,
                                input int bs, input int vd, input int strd, input int aln,
                                input int pi);
        int nmem, nsh;
        logic [45:0] mems [2];
        logic [45:0] shs [2];
        logic [45:0] wbv;
        bit wb;
        nmem = (nr >= 3) ? 2 : 1;
        nsh  = (el > 1) ? nr / el : 0;
        wb   = (pi != 15);
        for (int b = 0; b < 2; b++)
            mems[b] = mk(0, ((el > 1) ? SCR : 2 * vd) + 4 * b, 0, 16 * b, (b == 0) ? 1 : 0,
                         (b == 0) ? aln : 0, esz, bs, 0, 0, 0, 0);
        for (int s = 0; s < 2; s++)
            shs[s] = st ? mk(2, SCR + 4 * s, 2 * vd + 2 * s, 0, 0, 0, esz, bs, 0, 0, 0, 2 * strd)
                        : mk(2, 2 * vd + 2 * s, SCR + 4 * s, 0, 0, 0, esz, bs, 0, 0, 0, 2 * strd);
        wbv = (pi == 13) ? mk(1, 0, 0, 0, 0, 0, esz, bs, 1, 8 * nr, 0, 0)
                         : mk(1, 0, 0, 0, 0, 0, esz, bs, 0, 0, pi, 0);
        e_n = 0;
        if (st) begin
            for (int s = 0; s < nsh; s++) begin e_vec[e_n] = shs[s]; e_n++; end
            for (int b = 0; b < nmem; b++) begin e_vec[e_n] = mems[b]; e_n++; end
            if (wb) begin e_vec[e_n] = wbv; e_n++; end
        end else begin
            for (int b = 0; b < nmem; b++) begin e_vec[e_n] = mems[b]; e_n++; end
            if (wb) begin e_vec[e_n] = wbv; e_n++; end
            for (int s = 0; s < nsh; s++) begin e_vec[e_n] = shs[s]; e_n++; end
        end
        e_vec[e_n-1][43:42] = 2'b10;
    endtask

    function automatic string kind_tag(input logic [1:0] k);
        if (k == 2'd0) return "R2 R3 R7 R8";
        if (k == 2'd1) return "R4 R7 R8";
        return "R5 R6 R7 R8";
    endfunction

    task automatic run_one(input int num, input bit st, input int nr, input int el, input int pi);
        bit legal, done;
        int k, guard, esz, bs, vd, strd, aln;
        logic [45:0] act;
        bit rdy;
        esz  = num % 3;
        bs   = num % 13;
        vd   = (num * 7) % 32;
        strd = num % 4;
        aln  = (num / 3) % 4;
        legal = (nr >= 1 && nr <= 4 && el >= 1 && el <= 4) ? ((nr % el) == 0) : 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_store = st; in_nregs = 3'(nr); in_elems = 3'(el);
        in_esize = 2'(esz); in_base = 4'(bs); in_vd = 5'(vd); in_stride = 2'(strd);
        in_align = 2'(aln); in_postinc = 4'(pi);
        check(in_ready == 1'b1, "R9 idle before command", 64'(in_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (!legal) begin
            check(illegal == 1'b1 && uop_valid == 1'b0, "R1 illegal pulse",
                  64'({illegal, uop_valid}), 64'b10);
            @(negedge clk);
            check(illegal == 1'b0 && uop_valid == 1'b0 && in_ready == 1'b1,
                  "R1 pulse ends, nothing emitted", 64'({illegal, uop_valid, in_ready}), 64'b001);
            return;
        end
        check(illegal == 1'b0, "R1 legal not flagged", 64'(illegal), 64'd0);
        build_expect(st, nr, el, esz, bs, vd, strd, aln, pi);
        k = 0; guard = 0; done = 1'b0;
        while (!done) begin
            act = {uop_kind, uop_last, uop_delayed, uop_dst, uop_src, uop_offset, uop_align_en,
                   uop_align, uop_esize, uop_base, uop_use_imm, uop_imm, uop_incr_reg, uop_stride};
            check(uop_valid == 1'b1 && in_ready == 1'b0, "R9 busy while pending",
                  64'({uop_valid, in_ready}), 64'b10);
            check(act == e_vec[k], kind_tag(e_vec[k][45:44]), 64'(act), 64'(e_vec[k]));
            rdy = ((k + guard + num) % 3) != 0;
            uop_ready = rdy;
            @(posedge clk);
            if (rdy) begin
                if (k == e_n - 1) done = 1'b1;
                k++;
            end
            guard++;
            if (guard > 40) begin
                check(1'b0, "R9 sequence stalled", 64'(k), 64'(e_n));
                done = 1'b1;
            end
            @(negedge clk);
        end
        uop_ready = 1'b0;
        check(k == e_n, "R7 micro-op count", 64'(k), 64'(e_n));
        check(uop_valid == 1'b0 && in_ready == 1'b1, "R9 idle after last",
              64'({uop_valid, in_ready}), 64'b01);
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int num;
        int pis [3];
        pis[0] = 15; pis[1] = 13; pis[2] = 5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(uop_valid == 1'b0 && in_ready == 1'b1 && illegal == 1'b0, "R9 reset state",
              64'({uop_valid, in_ready, illegal}), 64'b010);
        num = 0;
        for (int st = 0; st < 2; st++)
            for (int nr = 0; nr < 8; nr++)
                for (int el = 0; el < 8; el++)
                    for (int p = 0; p < 3; p++) begin
                        run_one(num, st[0], nr, el, pis[p]);
                        num++;
                    end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule